// File: doc/BRIEF.md
# Ping-Pong Frame Fetch Sequencer

This block produces the memory read requests that feed a display controller's pixel path. Software describes up to two frame regions, each as a byte base and an inclusive byte ceiling. Once the raster is switched on, the block walks a region word by word in bursts of a programmable size and presents each burst on a valid/ready request port. When a region ends it switches to the other region if dual buffering is on, or starts the same region again if it is off. It pulses a separate end-of-frame output for each region.

A load-mode field selects one of three runs. A data-only run fetches frames without end. A palette-only run fetches region 0 once, pulses a palette-done output and then stops. A palette-plus-data run does one palette pass over region 0 and then carries on as a data run. The region bounds and the burst size are copied into working copies when a region starts, so software can prepare the next frame while the current one is being fetched. Clearing the enable stops the walk cleanly and sends the next start back to region 0.

Top module: `frame_fetch_seq`

## Requirements
- R1: Configuration writes go to byte offsets 0x28 (raster control: enable at bit 0, load mode at bits 21:20), 0x40 (DMA control: dual buffering at bit 0, burst code at bits 6:4), 0x44/0x48 (region 0 base/ceiling) and 0x4C/0x50 (region 1 base/ceiling). Bits 1:0 of base and ceiling are ignored, so requests are word aligned.
- R2: The burst code sets the request length in words: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16, and codes 5 to 7 give 16.
- R3: Bursts run upward from the base in full lengths. The last burst of a region is shortened so that its final word is the one that holds the ceiling byte, and no word beyond it is requested.
- R4: Once req_valid is high, it stays high with req_addr and req_len unchanged until the cycle in which req_ready is high.
- R5: With dual buffering on, accepting the last burst of region 0 pulses eof0 in the next cycle and fetching continues from region 1. Region 1 ends with eof1 and goes back to region 0, with no idle cycle in between.
- R6: With dual buffering off, every frame is fetched from region 0 and only eof0 pulses.
- R7: Load mode 1 (palette only) fetches region 0 once and pulses pal_done after its last burst is accepted. No further request is made until the enable is cleared and set again.
- R8: Load mode 0 (palette plus data) first makes one palette pass over region 0, ending with pal_done. It then fetches data frames as in load modes 2 and 3 (data only), starting again from region 0.
- R9: Base, ceiling and burst code are taken when a region's fetch starts. Writing them while that region is being fetched does not affect it until its next start.
- R10: Clearing the enable lets a pending request stay until it is accepted, and no request follows it. The next enable starts from region 0.
- R11: After reset no request is pending, no event is high and every configuration field reads as zero in its effect.
- R12: eof0, eof1 and pal_done are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | RW (8) | Configuration byte offset |
| cfg_wdata | input | AW (32) | Configuration write data |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted by memory |
| req_addr | output | AW (32) | Byte address of the first word of the burst |
| req_len | output | LW (5) | Burst length in words |
| eof0 | output | 1 | One-cycle pulse when region 0 is complete |
| eof1 | output | 1 | One-cycle pulse when region 1 is complete |
| pal_done | output | 1 | One-cycle pulse when a palette pass is complete |

## Verification
The assertions assume that every programmed ceiling is at or above its base. The ceiling check and the length bounds depend on this, because a reversed region would wrap the remaining-word count. They also assume that the memory side may hold req_ready low for any number of cycles. The stimulus writes only regions with the ceiling above the base and drives req_ready as constant high, constant low, or a random bit per cycle. The reference model in the bench runs on every edge and checks the request and event outputs against the requirements.

// File: rtl/frame_fetch_seq.sv
module frame_fetch_seq #(
  parameter int AW = 32,
  parameter int LW = 5,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [LW-1:0] req_len,
  output logic          eof0,
  output logic          eof1,
  output logic          pal_done
);
  localparam int WAW = AW - 2;
  localparam logic [RW-1:0] OFF_RCTL = RW'(8'h28);
  localparam logic [RW-1:0] OFF_DCTL = RW'(8'h40);
  localparam logic [RW-1:0] OFF_B0   = RW'(8'h44);
  localparam logic [RW-1:0] OFF_C0   = RW'(8'h48);
  localparam logic [RW-1:0] OFF_B1   = RW'(8'h4C);
  localparam logic [RW-1:0] OFF_C1   = RW'(8'h50);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HALT} st_t;

  logic           en_q, dual_q;
  logic [1:0]     mode_q;
  logic [2:0]     bcode_q;
  logic [WAW-1:0] b0_q, c0_q, b1_q, c1_q;

  st_t            st;
  logic           sel, pal_ph, pal_only;
  logic [WAW-1:0] cur_w, lim_w;
  logic [2:0]     bsh;

  logic [LW-1:0]  blen;
  logic [WAW-1:0] rem;
  logic           last, hs, nsel;

  logic unused_lowbits;
  assign unused_lowbits = ^cfg_wdata[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; dual_q <= 1'b0; mode_q <= 2'd0; bcode_q <= 3'd0;
      b0_q <= '0; c0_q <= '0; b1_q <= '0; c1_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFF_RCTL: begin en_q <= cfg_wdata[0]; mode_q <= cfg_wdata[21:20]; end
        OFF_DCTL: begin dual_q <= cfg_wdata[0]; bcode_q <= cfg_wdata[6:4]; end
        OFF_B0:   b0_q <= cfg_wdata[AW-1:2];
        OFF_C0:   c0_q <= cfg_wdata[AW-1:2];
        OFF_B1:   b1_q <= cfg_wdata[AW-1:2];
        OFF_C1:   c1_q <= cfg_wdata[AW-1:2];
        default: ;
      endcase
    end
  end

  assign blen      = (bsh > 3'd4) ? LW'(16) : (LW'(1) << bsh);
  assign rem       = lim_w - cur_w + WAW'(1);
  assign last      = rem <= WAW'(blen);
  assign req_valid = (st == S_RUN);
  assign req_addr  = {cur_w, 2'b00};
  assign req_len   = last ? rem[LW-1:0] : blen;
  assign hs        = req_valid & req_ready;
  assign nsel      = dual_q & ~sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sel <= 1'b0; pal_ph <= 1'b0; pal_only <= 1'b0;
      cur_w <= '0; lim_w <= '0; bsh <= 3'd0;
      eof0 <= 1'b0; eof1 <= 1'b0; pal_done <= 1'b0;
    end else begin
      eof0 <= 1'b0; eof1 <= 1'b0; pal_done <= 1'b0;
      case (st)
        S_IDLE: if (en_q) begin
          st <= S_RUN; sel <= 1'b0;
          pal_ph <= ~mode_q[1]; pal_only <= (mode_q == 2'd1);
          cur_w <= b0_q; lim_w <= c0_q; bsh <= bcode_q;
        end
        S_RUN: if (hs) begin
          if (last) begin
            pal_done <= pal_ph;
            eof0 <= ~pal_ph & ~sel;
            eof1 <= ~pal_ph & sel;
            if (!en_q) begin
              st <= S_IDLE; sel <= 1'b0;
            end else if (pal_ph && pal_only) begin
              st <= S_HALT;
            end else if (pal_ph) begin
              pal_ph <= 1'b0; sel <= 1'b0;
              cur_w <= b0_q; lim_w <= c0_q; bsh <= bcode_q;
            end else begin
              sel <= nsel; bsh <= bcode_q;
              cur_w <= nsel ? b1_q : b0_q;
              lim_w <= nsel ? c1_q : c0_q;
            end
          end else begin
            cur_w <= cur_w + WAW'(blen);
            if (!en_q) begin st <= S_IDLE; sel <= 1'b0; end
          end
        end
        S_HALT: if (!en_q) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_fetch_seq_chk.sv
module frame_fetch_seq_chk #(
  parameter int AW = 32,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [LW-1:0] req_len,
  input logic          eof0,
  input logic          eof1,
  input logic          pal_done,
  input logic          en,
  input logic [AW-3:0] lim_w
);
  logic [AW-1:0] end_w;
  logic unused_chk;
  assign end_w = AW'(req_addr[AW-1:2]) + AW'(req_len) - AW'(1);
  assign unused_chk = ^req_addr[1:0];

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));

  a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= LW'(16)));

  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> end_w <= AW'(lim_w));

  a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eof0, eof1, pal_done}));

  a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !req_valid |=> !req_valid);
endmodule

bind frame_fetch_seq frame_fetch_seq_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_len(req_len), .eof0(eof0), .eof1(eof1),
  .pal_done(pal_done), .en(en_q), .lim_w(lim_w)
);

// File: tb/sim_frame_fetch_seq.sv
module sim_frame_fetch_seq;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_RCTL = 8'h28, A_DCTL = 8'h40,
                         A_B0 = 8'h44, A_C0 = 8'h48, A_B1 = 8'h4C, A_C1 = 8'h50;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic req_valid, req_ready = 0;
  logic [31:0] req_addr;
  logic [4:0] req_len;
  logic eof0, eof1, pal_done;

  frame_fetch_seq u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .eof0(eof0), .eof1(eof1), .pal_done(pal_done));

  always #(CLK_P/2) clk = ~clk;

  int ntest = 0, nfail = 0;
  string tag = "R11";
  int rmode = 1;
  always @(negedge clk) req_ready = (rmode == 0) ? 1'b0 : (rmode == 1) ? 1'b1 : 1'($urandom % 2);

  // reference model
  int r_en, r_mode, r_dual, r_code, rb[2], rc[2];
  int ms, msel, mpal, mmode, mcur, mlim, mb;
  bit m_e0, m_e1, m_pd;

  function automatic int words(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int mlen();
    int rem = mlim - mcur + 1;
    return (rem < words(mb)) ? rem : words(mb);
  endfunction

  task automatic mload(int n);
    mcur = rb[n] / 4; mlim = rc[n] / 4; mb = r_code;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_en = 0; r_mode = 0; r_dual = 0; r_code = 0;
      rb[0] = 0; rb[1] = 0; rc[0] = 0; rc[1] = 0;
      ms = 0; msel = 0; mpal = 0; mmode = 0; mcur = 0; mlim = 0; mb = 0;
      m_e0 = 0; m_e1 = 0; m_pd = 0;
    end else begin
      m_e0 = 0; m_e1 = 0; m_pd = 0;
      if (ms == 1) begin
        if (req_ready) begin
          if (mlim - mcur + 1 <= words(mb)) begin
            if (mpal != 0) m_pd = 1; else if (msel != 0) m_e1 = 1; else m_e0 = 1;
            if (r_en == 0) begin ms = 0; msel = 0; end
            else if (mpal != 0 && mmode == 1) ms = 2;
            else if (mpal != 0) begin mpal = 0; msel = 0; mload(0); end
            else begin msel = (r_dual != 0) ? 1 - msel : 0; mload(msel); end
          end else begin
            mcur = mcur + words(mb);
            if (r_en == 0) begin ms = 0; msel = 0; end
          end
        end
      end else if (ms == 0) begin
        if (r_en != 0) begin
          ms = 1; msel = 0; mmode = r_mode; mpal = (r_mode < 2) ? 1 : 0; mload(0);
        end
      end else if (r_en == 0) ms = 0;
      if (cfg_we) begin
        case (cfg_addr)
          A_RCTL: begin r_en = int'(cfg_wdata[0]); r_mode = int'(cfg_wdata[21:20]); end
          A_DCTL: begin r_dual = int'(cfg_wdata[0]); r_code = int'(cfg_wdata[6:4]); end
          A_B0: rb[0] = int'(cfg_wdata & 32'hFFFF_FFFC);
          A_C0: rc[0] = int'(cfg_wdata & 32'hFFFF_FFFC);
          A_B1: rb[1] = int'(cfg_wdata & 32'hFFFF_FFFC);
          A_C1: rc[1] = int'(cfg_wdata & 32'hFFFF_FFFC);
          default: ;
        endcase
      end
    end
  end

  // monitors
  int hs_a[$], hs_l[$], ev[$];
  always @(posedge clk) if (rst_n && req_valid && req_ready) begin
    hs_a.push_back(int'(req_addr)); hs_l.push_back(int'(req_len));
  end

  always begin
    @(posedge clk); #(CLK_P/4);
    if (rst_n) begin
      bit bad;
      bad = (req_valid !== (ms == 1)) || (eof0 !== m_e0) || (eof1 !== m_e1) || (pal_done !== m_pd);
      if (ms == 1 && (int'(req_addr) != mcur * 4 || int'(req_len) != mlen())) bad = 1;
      ntest++;
      if (bad) begin
        nfail++;
        $display("FAIL %s cycle: valid=%0b addr=%h len=%0d ev=%b%b%b exp valid=%0b addr=%h len=%0d ev=%b%b%b",
          tag, req_valid, req_addr, req_len, eof0, eof1, pal_done,
          ms == 1, mcur * 4, (ms == 1) ? mlen() : 0, m_e0, m_e1, m_pd);
      end
      ntest++;
      if ($countones({eof0, eof1, pal_done}) > 1) begin
        nfail++;
        $display("FAIL R12: events=%b%b%b expected at most one", eof0, eof1, pal_done);
      end
      if (eof0) ev.push_back(0);
      if (eof1) ev.push_back(1);
      if (pal_done) ev.push_back(2);
    end
  end

  task automatic chk(string t, int act, int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d (0x%h) expected=%0d (0x%h)", t, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic samp();
    @(posedge clk); #(CLK_P/4);
  endtask

  task automatic quiesce();
    rmode = 1;
    wr(A_RCTL, 0);
    repeat (4) @(negedge clk);
    hs_a.delete(); hs_l.delete(); ev.delete();
  endtask

  task automatic setup(int mode, int dual, int code, int b0, int c0, int b1, int c1);
    quiesce();
    wr(A_DCTL, 32'(dual) | (32'(code) << 4));
    wr(A_B0, 32'(b0)); wr(A_C0, 32'(c0)); wr(A_B1, 32'(b1)); wr(A_C1, 32'(c1));
    wr(A_RCTL, (32'(mode) << 20) | 32'h1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int n0, n1, nold;
    repeat (3) @(negedge clk);
    rst_n = 1;
    samp();
    chk("R11 valid after reset", int'(req_valid), 0);
    chk("R11 events after reset", int'({eof0, eof1, pal_done}), 0);

    // R1: offsets and ignored low address bits
    tag = "R1";
    rmode = 0;
    wr(A_DCTL, 32'h20);
    wr(A_B0, 32'h1003); wr(A_C0, 32'h10FF);
    wr(A_RCTL, 32'h0020_0001);
    samp(); samp();
    chk("R1 first address", int'(req_addr), 32'h1000);
    chk("R1 first length", int'(req_len), 4);

    // R2: every burst code
    tag = "R2";
    for (int c = 0; c < 8; c++) begin
      quiesce();
      rmode = 0;
      wr(A_DCTL, 32'(c) << 4);
      wr(A_RCTL, 32'h0020_0001);
      samp(); samp();
      chk($sformatf("R2 code %0d length", c), int'(req_len), (c > 4) ? 16 : (1 << c));
    end

    // R3: shortened final burst, inclusive ceiling
    tag = "R3";
    setup(2, 0, 3, 32'h2000, 32'h2027, 0, 0);
    repeat (40) @(negedge clk);
    chk("R3 full burst", hs_l[0], 8);
    chk("R3 short burst", hs_l[1], 2);
    chk("R3 short burst addr", hs_a[1], 32'h2020);
    chk("R3 restart at base", hs_a[2], 32'h2000);

    // R4: random ready
    tag = "R4";
    setup(2, 1, 2, 32'h3000, 32'h305B, 32'h5000, 32'h5013);
    rmode = 2;
    repeat (300) @(negedge clk);

    // R5: dual alternation
    tag = "R5";
    setup(2, 1, 1, 32'h6000, 32'h600F, 32'h7000, 32'h701B);
    rmode = 2;
    repeat (200) @(negedge clk);
    n0 = 0; n1 = 0;
    foreach (ev[i]) begin
      if (ev[i] == 0) n0++; else if (ev[i] == 1) n1++;
      if (i > 0) chk("R5 alternation", ev[i], 1 - ev[i-1]);
    end
    chk("R5 first event is eof0", ev[0], 0);
    chk("R5 eof1 seen", int'(n1 > 2), 1);

    // R6: dual off
    tag = "R6";
    setup(2, 0, 2, 32'h6000, 32'h600F, 32'h7000, 32'h701B);
    repeat (60) @(negedge clk);
    n0 = 0; n1 = 0;
    foreach (ev[i]) if (ev[i] == 0) n0++; else n1++;
    chk("R6 no eof1", n1, 0);
    chk("R6 eof0 repeats", int'(n0 > 3), 1);

    // R7: palette only
    tag = "R7";
    setup(1, 1, 2, 32'h8000, 32'h801F, 32'h9000, 32'h901F);
    repeat (40) @(negedge clk);
    chk("R7 single event", ev.size(), 1);
    chk("R7 event is pal_done", ev[0], 2);
    samp();
    chk("R7 halted", int'(req_valid), 0);

    // R8: palette then data
    tag = "R8";
    setup(0, 1, 2, 32'h8000, 32'h801F, 32'h9000, 32'h901F);
    repeat (60) @(negedge clk);
    chk("R8 palette first", ev[0], 2);
    chk("R8 data from region 0", ev[1], 0);
    chk("R8 then region 1", ev[2], 1);

    // R9: shadow copies
    tag = "R9";
    setup(2, 0, 0, 32'h3000, 32'h303F, 0, 0);
    repeat (3) @(negedge clk);
    wr(A_B0, 32'h4000); wr(A_C0, 32'h400F);
    wr(A_DCTL, 32'h10);
    repeat (40) @(negedge clk);
    nold = 0;
    foreach (hs_a[i]) if (hs_a[i] >= 32'h3000 && hs_a[i] < 32'h3040) nold++;
    chk("R9 old frame completes", nold, 16);
    chk("R9 new base next frame", hs_a[16], 32'h4000);
    chk("R9 new burst next frame", hs_l[16], 2);

    // R10: abort and restart
    tag = "R10";
    setup(2, 1, 2, 32'hA000, 32'hA0FF, 32'hB000, 32'hB0FF);
    repeat (5) @(negedge clk);
    rmode = 0;
    repeat (3) @(negedge clk);
    wr(A_RCTL, 32'h0020_0000);
    samp();
    chk("R10 pending held", int'(req_valid), 1);
    rmode = 1;
    samp(); samp();
    chk("R10 stopped", int'(req_valid), 0);
    repeat (3) samp();
    chk("R10 still stopped", int'(req_valid), 0);
    rmode = 0;
    wr(A_RCTL, 32'h0020_0001);
    samp();
    chk("R10 restart address", int'(req_addr), 32'hA000);

    quiesce();
    summary();
  end
endmodule